// File: doc/BRIEF.md
# Multi-Mode Host Bus Front End

This block is the host-facing front end of a display controller. A microprocessor reaches the controller over one shared set of pins. The pins carry one of three transfer styles: a parallel bus with separate active-low read and write strobes (8080 style), a parallel bus with an active-high enable and a read/write select (6800 style), or a write-only serial link carried on two of the data pins. Two static strap inputs choose the style. Every transfer is qualified by a chip select made of two inputs of opposite polarity. A separate address line marks each byte as either a command or display data.

All host pins are asynchronous to the controller clock. They pass through a bank of two-flop synchronizers. Strobe edges are then detected in the clock domain. Each completed write becomes a single-cycle pulse toward the internal logic, together with the byte and a data/command flag. On parallel reads the block puts the internal read data on the data pins and raises all eight output enables. The enables are decoded straight from the pins, so the bus turns around without waiting on the synchronizers.

The host must hold data, the address line and chip select for at least three controller clock cycles after the strobe edge that ends a write, and for at least three cycles around each serial clock level. Reset is synchronous and active low. The interface stays in its initial state for as long as reset is held.

Top module: `hostbus_front`

## Requirements
- R1: While `rst_n` is low, `wr_pulse` stays 0 and `pin_oe` is all zeros.
- R2: The chip is selected only when `csel_n` is 0 and `csel` is 1. When it is not selected, `pin_oe` is all zeros and no write pulse is produced for any strobe activity.
- R3: With `strap_m68`=0 and `strap_par`=1, a rising edge on `wr_rw` (write strobe, active low) produces one write of `pin_in`. `wr_is_data` equals `dc_sel` (1 = display data, 0 = command).
- R4: With `strap_m68`=0 and `strap_par`=1, while selected and `rd_e` (read strobe) is 0, `pin_oe` is 8'hFF and `pin_out` equals `rd_data`. With `rd_e` at 1, `pin_oe` is 0.
- R5: With `strap_m68`=1 and `strap_par`=1, a falling edge on `rd_e` (enable) while `wr_rw`=0 produces one write of `pin_in`, with `wr_is_data` equal to `dc_sel`.
- R6: With `strap_m68`=1 and `strap_par`=1, `pin_oe` is 8'hFF only while selected, `rd_e`=1 and `wr_rw`=1. With `wr_rw`=0 it is 0.
- R7: With `strap_par`=0, `pin_in[7]` is serial data and `pin_in[6]` is serial clock. Bits are taken on the clock's rising edge, most significant bit first. After the eighth bit one write is produced, with `wr_is_data` taken as `dc_sel` at that eighth edge.
- R8: In serial mode, deselecting the chip discards any partial byte. The next eight bits form a fresh byte.
- R9: In serial mode, `rd_e` and `wr_rw` have no effect: `pin_oe` stays all zeros and no write pulse results from them.
- R10: `wr_pulse` is one clock wide and never high on two consecutive cycles. Each accepted transfer yields exactly one pulse.
- R11: In parallel mode, activity on `pin_in` (including bit 6) without a write strobe edge produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_m68 | input | 1 | Static strap: 1 = 6800-style, 0 = 8080-style parallel protocol |
| strap_par | input | 1 | Static strap: 1 = parallel, 0 = serial |
| csel_n | input | 1 | Active-low chip select |
| csel | input | 1 | Active-high chip select |
| dc_sel | input | 1 | 1 = display data, 0 = command |
| rd_e | input | 1 | 8080 read strobe (active low) or 6800 enable (active high) |
| wr_rw | input | 1 | 8080 write strobe (active low) or 6800 read/write select (1 = read) |
| pin_in | input | 8 | Input side of the data pins |
| pin_out | output | 8 | Output side of the data pins |
| pin_oe | output | 8 | Per-pin output enables, 1 = drive |
| rd_data | input | 8 | Read byte from the internal logic |
| wr_pulse | output | 1 | Single-cycle write strobe toward the internal logic |
| wr_byte | output | 8 | Written byte, valid while `wr_pulse` is high |
| wr_is_data | output | 1 | Data/command flag, valid while `wr_pulse` is high |

## Verification
The bench targets the serial bit order and the eighth-edge completion. A reversed shifter would hand over a bit-mirrored byte, and an off-by-one counter would emit a byte a clock early or absorb a bit of the next one. It breaks a serial byte by deselecting partway through. A counter that survives deselection would merge the stale bits into the following byte and produce a wrong value. It also toggles the write-strobe pin and pin 6 in the wrong mode, and checks the chip-select polarities and the 6800 read/write qualification of both writes and output enables. A design that mixed these up would show spurious scoreboard entries or driven pins during writes.

// File: rtl/hbf_pkg.sv
// Shared types for the host bus front end.
package hbf_pkg;
    localparam int BYTE_W = 8;

    // One accepted host write: flag plus byte.
    typedef struct packed {
        logic              is_data;
        logic [BYTE_W-1:0] val;
    } hb_xfer_t;
endpackage

// File: rtl/hbf_sync.sv
// Multi-stage synchronizer bank.
// Assumes: each input bit is individually asynchronous; multi-bit words are
// only consumed while the host holds them stable (see top-level header).
module hbf_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop samples the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later flops resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbf_par_rx.sv
// Parallel write receiver for both 8080-style and 6800-style buses.
// 8080: write taken on rising edge of the active-low write strobe.
// 6800: write taken on falling edge of enable while read/write is low.
// Assumes: all inputs already synchronized; straps static; armed goes high
// only once the edge-detect history holds real pin values.
module hbf_par_rx
    import hbf_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          m68,
    input  logic          armed,
    input  logic          sel_s,
    input  logic          dc_s,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic [DW-1:0] dat_s,
    output logic          fire,
    output hb_xfer_t      xfer
);
    logic rd_prev, wr_prev;
    logic ev_i80, ev_m68, ev;

    // Remember last synchronized strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_s;
            wr_prev <= wr_s;
        end
    end

    // Decode the write-completing edge for the selected protocol.
    always_comb begin
        ev_i80 = wr_s & ~wr_prev;
        ev_m68 = ~rd_s & rd_prev & ~wr_s;
        ev     = armed & enable & sel_s & (m68 ? ev_m68 : ev_i80);
    end

    // Register the pulse and hold the captured byte until the next write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire <= 1'b0;
            xfer <= '0;
        end else begin
            fire <= ev;
            if (ev) xfer <= '{is_data: dc_s, val: dat_s};
        end
    end

    // R2: a parallel write only follows a cycle in which the chip was selected.
    a_r2_par_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(sel_s));

    // R9: the parallel receiver never fires while serial mode is strapped.
    a_r9_par_quiet_serial: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fire);
endmodule

// File: rtl/hbf_ser_rx.sv
// Write-only serial receiver: MSB first, sampled on serial clock rise,
// data/command flag taken with the eighth bit.
// Assumes: inputs synchronized; host keeps each serial clock level for
// several controller cycles; deselect discards any partial byte.
module hbf_ser_rx
    import hbf_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     armed,
    input  logic     sel_s,
    input  logic     dc_s,
    input  logic     sdi_s,
    input  logic     sck_s,
    output logic     fire,
    output hb_xfer_t xfer
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic          sck_prev;
    logic [CW-1:0] cnt;
    logic [DW-2:0] sh;
    logic          sck_rise;

    // Serial clock rising edge, valid only once history is real.
    assign sck_rise = armed & sck_s & ~sck_prev;

    // Track previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Shift bits in, count them, and emit a byte on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sh   <= '0;
            fire <= 1'b0;
            xfer <= '0;
        end else begin
            fire <= 1'b0;
            if (!enable || !sel_s) begin
                cnt <= '0;
            end else if (sck_rise) begin
                if (cnt == LAST) begin
                    fire <= 1'b1;
                    xfer <= '{is_data: dc_s, val: {sh, sdi_s}};
                    cnt  <= '0;
                end else begin
                    sh  <= {sh[DW-3:0], sdi_s};
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R7: a serial byte completes only on the final bit of the count.
    a_r7_byte_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(cnt) == LAST);

    // R8: deselecting clears the bit count so a partial byte is lost.
    a_r8_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s |=> cnt == '0);
endmodule

// File: rtl/hostbus_front.sv
// Host bus front end for a display controller.
// Combines 8080-style, 6800-style and serial write paths behind one pin set,
// forwards one-cycle write pulses, and decodes the data pin output enables.
// Assumes: straps are static; host holds data, address line and chip select
// at least SYNC_STAGES+1 clocks past the strobe edge that ends a write.
module hostbus_front
    import hbf_pkg::*;
#(
    parameter int DW          = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_m68,
    input  logic          strap_par,
    input  logic          csel_n,
    input  logic          csel,
    input  logic          dc_sel,
    input  logic          rd_e,
    input  logic          wr_rw,
    input  logic [DW-1:0] pin_in,
    output logic [DW-1:0] pin_out,
    output logic [DW-1:0] pin_oe,
    input  logic [DW-1:0] rd_data,
    output logic          wr_pulse,
    output logic [DW-1:0] wr_byte,
    output logic          wr_is_data
);
    localparam int SW     = DW + 4;
    localparam int WARM   = SYNC_STAGES + 1;
    localparam int WCW    = $clog2(WARM + 1);
    localparam int SDI_IX = DW - 1;
    localparam int SCK_IX = DW - 2;

    logic           sel_raw;
    logic [SW-1:0]  raw_v, syn_v;
    logic           sel_s, dc_s, rd_s, wr_s;
    logic [DW-1:0]  dat_s;
    logic [WCW-1:0] warm;
    logic           armed;
    logic           rd_drive;
    logic           par_fire, ser_fire;
    hb_xfer_t       par_x, ser_x;

    assign sel_raw = ~csel_n & csel;
    assign raw_v   = {sel_raw, dc_sel, rd_e, wr_rw, pin_in};

    hbf_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    assign {sel_s, dc_s, rd_s, wr_s, dat_s} = syn_v;

    // Hold off edge detection until the synchronizer and history are filled.
    always_ff @(posedge clk) begin
        if (!rst_n)     warm <= '0;
        else if (!armed) warm <= warm + 1'b1;
    end
    assign armed = (warm == WCW'(WARM));

    hbf_par_rx #(.DW(DW)) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (strap_par),
        .m68    (strap_m68),
        .armed  (armed),
        .sel_s  (sel_s),
        .dc_s   (dc_s),
        .rd_s   (rd_s),
        .wr_s   (wr_s),
        .dat_s  (dat_s),
        .fire   (par_fire),
        .xfer   (par_x)
    );

    hbf_ser_rx #(.DW(DW)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (~strap_par),
        .armed  (armed),
        .sel_s  (sel_s),
        .dc_s   (dc_s),
        .sdi_s  (dat_s[SDI_IX]),
        .sck_s  (dat_s[SCK_IX]),
        .fire   (ser_fire),
        .xfer   (ser_x)
    );

    // Select the active write path's outputs.
    always_comb begin
        if (strap_par) begin
            wr_pulse   = par_fire;
            wr_byte    = par_x.val;
            wr_is_data = par_x.is_data;
        end else begin
            wr_pulse   = ser_fire;
            wr_byte    = ser_x.val;
            wr_is_data = ser_x.is_data;
        end
    end

    // Decode the read window directly from the pins for fast bus turnaround.
    always_comb begin
        if (!rst_n || !sel_raw || !strap_par) rd_drive = 1'b0;
        else if (strap_m68)                   rd_drive = rd_e & wr_rw;
        else                                  rd_drive = ~rd_e;
    end

    assign pin_oe  = {DW{rd_drive}};
    assign pin_out = rd_data;

    // R10: the internal write strobe is a single-cycle pulse.
    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R10: the two receivers never fire together.
    a_r10_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({par_fire, ser_fire}));

    // R4: data pins turn around as a whole byte, never partially.
    a_r4_oe_whole_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_oe) == 0 || $countones(pin_oe) == DW);
endmodule

// File: tb/test_hostbus_front.sv
module test_hostbus_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_m68 = 1'b0, strap_par = 1'b1;
    logic       csel_n = 1'b1, csel = 1'b0;
    logic       dc_sel = 1'b0, rd_e = 1'b1, wr_rw = 1'b1;
    logic [7:0] pin_in = 8'h00, rd_data = 8'h00;
    logic [7:0] pin_out, pin_oe, wr_byte;
    logic       wr_pulse, wr_is_data;

    int n_chk = 0, n_bad = 0, n_seen = 0;
    bit done = 1'b0;
    logic [8:0] exp_q[$];
    logic prev_pulse = 1'b0;

    always #4 clk = ~clk;

    hostbus_front i_hostbus_front (
        .clk(clk), .rst_n(rst_n), .strap_m68(strap_m68), .strap_par(strap_par),
        .csel_n(csel_n), .csel(csel), .dc_sel(dc_sel), .rd_e(rd_e), .wr_rw(wr_rw),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .rd_data(rd_data),
        .wr_pulse(wr_pulse), .wr_byte(wr_byte), .wr_is_data(wr_is_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop expected writes and compare as pulses appear.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (wr_pulse) begin
                n_seen++;
                chk(!prev_pulse, "R10 pulse wider than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R9/R11 unexpected write", {wr_is_data, wr_byte}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({wr_is_data, wr_byte} == e, "R3/R5/R7 write byte and flag",
                        {wr_is_data, wr_byte}, e);
                end
            end
            prev_pulse = wr_pulse;
        end
    end

    task automatic do_reset(input logic m68, input logic par);
        strap_m68 = m68;
        strap_par = par;
        rd_e      = m68 ? 1'b0 : 1'b1;
        wr_rw     = 1'b1;
        pin_in    = 8'h00;
        csel_n    = 1'b1;
        csel      = 1'b0;
        rst_n     = 1'b0;
        wait_n(2);
        csel_n = 1'b0; csel = 1'b1;
        if (par && !m68) rd_e = 1'b0;
        #1;
        chk(pin_oe == 8'h00, "R1 oe in reset", pin_oe, 0);
        chk(wr_pulse == 1'b0, "R1 pulse in reset", wr_pulse, 0);
        rd_e = m68 ? 1'b0 : 1'b1;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(6);
    endtask

    task automatic wr80(input logic dc, input logic [7:0] b, input bit expect_it);
        pin_in = b; dc_sel = dc;
        if (expect_it) exp_q.push_back({dc, b});
        wait_n(3); wr_rw = 1'b0;
        wait_n(3); wr_rw = 1'b1;
        wait_n(6);
    endtask

    task automatic wr68(input logic dc, input logic [7:0] b);
        pin_in = b; dc_sel = dc; wr_rw = 1'b0;
        exp_q.push_back({dc, b});
        wait_n(3); rd_e = 1'b1;
        wait_n(3); rd_e = 1'b0;
        wait_n(4); wr_rw = 1'b1;
        wait_n(4);
    endtask

    task automatic ser_bits(input logic dc, input logic [7:0] b, input int nbits);
        dc_sel = dc;
        for (int i = 7; i > 7 - nbits; i--) begin
            pin_in[7] = b[i]; pin_in[6] = 1'b0;
            wait_n(3);
            pin_in[6] = 1'b1;
            wait_n(3);
        end
        pin_in[6] = 1'b0;
        wait_n(6);
    endtask

    task automatic drained(input string tag);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        int base;
        // ---- 8080 parallel ----
        do_reset(1'b0, 1'b1);
        wr80(1'b0, 8'h3C, 1'b1);
        wr80(1'b1, 8'hA5, 1'b1);
        drained("R3 8080 writes delivered");
        base = n_seen;
        csel_n = 1'b1; wr80(1'b1, 8'h77, 1'b0);
        csel_n = 1'b0; csel = 1'b0; wr80(1'b1, 8'h66, 1'b0);
        csel = 1'b1;
        chk(n_seen == base, "R2 no write when deselected", n_seen - base, 0);
        rd_data = 8'hC9; rd_e = 1'b0; #1;
        chk(pin_oe == 8'hFF, "R4 oe during read", pin_oe, 8'hFF);
        chk(pin_out == 8'hC9, "R4 read data", pin_out, 8'hC9);
        csel_n = 1'b1; #1;
        chk(pin_oe == 8'h00, "R2 oe when deselected", pin_oe, 0);
        csel_n = 1'b0; rd_e = 1'b1; #1;
        chk(pin_oe == 8'h00, "R4 oe idle", pin_oe, 0);
        base = n_seen;
        for (int k = 0; k < 6; k++) begin
            pin_in = (k % 2 == 0) ? 8'h40 : 8'hBF;
            wait_n(4);
        end
        chk(n_seen == base, "R11 pin activity without strobe", n_seen - base, 0);
        // ---- 6800 parallel ----
        do_reset(1'b1, 1'b1);
        wr68(1'b1, 8'h5A);
        wr68(1'b0, 8'hC3);
        drained("R5 6800 writes delivered");
        rd_data = 8'h1E; wr_rw = 1'b1; rd_e = 1'b1; #1;
        chk(pin_oe == 8'hFF, "R6 oe with enable high and read", pin_oe, 8'hFF);
        chk(pin_out == 8'h1E, "R6 read data", pin_out, 8'h1E);
        wr_rw = 1'b0; #1;
        chk(pin_oe == 8'h00, "R6 oe with write select", pin_oe, 0);
        wr_rw = 1'b1; csel = 1'b0; #1;
        chk(pin_oe == 8'h00, "R2 6800 oe deselected", pin_oe, 0);
        csel = 1'b1; rd_e = 1'b0; #1;
        chk(pin_oe == 8'h00, "R6 oe enable low", pin_oe, 0);
        wait_n(6);
        // ---- serial ----
        do_reset(1'b0, 1'b0);
        exp_q.push_back({1'b1, 8'h96}); ser_bits(1'b1, 8'h96, 8);
        exp_q.push_back({1'b0, 8'h01}); ser_bits(1'b0, 8'h01, 8);
        drained("R7 serial bytes delivered");
        ser_bits(1'b1, 8'hFF, 3);
        csel_n = 1'b1; wait_n(5); csel_n = 1'b0; wait_n(5);
        exp_q.push_back({1'b1, 8'hE7}); ser_bits(1'b1, 8'hE7, 8);
        drained("R8 partial byte discarded");
        base = n_seen;
        rd_e = 1'b0; #1;
        chk(pin_oe == 8'h00, "R9 no drive in serial", pin_oe, 0);
        for (int k = 0; k < 4; k++) begin
            wr_rw = 1'b0; wait_n(3); wr_rw = 1'b1; wait_n(3);
        end
        rd_e = 1'b1;
        wait_n(6);
        chk(n_seen == base, "R9 strobes ignored in serial", n_seen - base, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog R1-all actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule